// File: doc/BRIEF.md
# Multidrop Scan Slot Address Selector

This block sits next to the test access port controller of a scan bridge that shares one backplane test bus with many peers. When the TAP finishes an address load into its instruction register, the block compares the loaded value against the device's static slot identity pins. It decides whether this device joins the following scan operations and whether it may drive the shared backplane test data output.

Besides a one-to-one slot match, the block recognises three kinds of reserved codes. A broadcast code selects every device. An interrogation code selects the device and lets it drive its data output so the master can sample it. A multicast code selects only the devices whose group register holds the matching group number. The group register is written from a data-register update while the device is selected. An address-mask input drops the low slot bits from the comparison so that one code reaches a cluster of adjacent slots.

Top module: `jtag_slot_selector`

## Requirements
- R1: After the asynchronous reset, `selected` and `bp_tdo_oe` are 0 and the multicast group register holds 0.
- R2: An address load whose value equals `slot_id` (not a reserved code, not zero) sets `selected` and `bp_tdo_oe` on the clock edge that samples the load.
- R3: An address load that matches nothing clears both `selected` and `bp_tdo_oe`.
- R4: A `slot_id` of all zeros never matches as a unique slot, whatever value is loaded and whatever the mask is.
- R5: With `addr_mask` high, the lowest MASK_LSBS bits (default 2) of the loaded value and of `slot_id` are left out of the unique comparison. With `addr_mask` low, every bit counts.
- R6: Loading the broadcast code 8'h38 sets `selected` and leaves `bp_tdo_oe` at 0.
- R7: Loading the interrogation code 8'h3A sets both `selected` and `bp_tdo_oe`.
- R8: Loading a multicast code 8'h3C + g (g = 0..3) sets `selected` with `bp_tdo_oe` at 0 only when the group register equals g. Otherwise the device is deselected.
- R9: A group write (`grp_upd` high) stores `grp_din` only while `selected` is 1. When the device is not selected, the write is ignored.
- R10: A cycle with `tap_tlr` high clears `selected` and `bp_tdo_oe` on that edge and leaves the group register unchanged. It takes priority over an address load in the same cycle.
- R11: The reserved codes are always decoded as reserved, even when `slot_id` equals one of them: a slot of 8'h38 loaded with 8'h38 behaves as broadcast.
- R12: Without an address load or a reset state, `selected` and `bp_tdo_oe` keep their values.
- R13: `bp_tdo_oe` is never 1 while `selected` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tap_tlr | input | 1 | High while the TAP is in Test-Logic-Reset |
| upd_ir_addr | input | 1 | One-cycle strobe: Update-IR of an address load |
| ir_addr | input | ADDR_W | Value held in the instruction register at the strobe |
| slot_id | input | ADDR_W | Static slot identity pins |
| addr_mask | input | 1 | Ignore the low MASK_LSBS bits in the unique comparison |
| grp_upd | input | 1 | One-cycle strobe: Update-DR of the group register |
| grp_din | input | GROUP_W | Group number presented at the group update |
| selected | output | 1 | Device takes part in scan operations |
| bp_tdo_oe | output | 1 | Enable for the backplane test data output driver |

## Verification
On every cycle, the assertions hold the output-enable-implies-selected rule and the stability of both flags between address loads. They also check that Test-Logic-Reset clears the selection, that a group write is ignored when the device is not selected, and that broadcast, interrogation and zero-slot loads give their fixed results one edge later. Only the bench scenarios show the masked and unmasked comparison against real slot values, the effect of a multicast code against a previously written group, the priority of reserved codes over an equal slot value, and the fact that the group survives Test-Logic-Reset but not the asynchronous reset.

// File: rtl/slot_sel_pkg.sv
package slot_sel_pkg;

   typedef enum logic [2:0] {
      KIND_NONE     = 3'd0,
      KIND_UNIQUE   = 3'd1,
      KIND_BCAST    = 3'd2,
      KIND_MCAST    = 3'd3,
      KIND_INTERROG = 3'd4
   } sel_kind_e;

   localparam int unsigned CODE_BCAST      = 32'h38;
   localparam int unsigned CODE_INTERROG   = 32'h3A;
   localparam int unsigned CODE_MCAST_BASE = 32'h3C;
   localparam int unsigned CODE_MIN_W      = 6;

endpackage

// File: rtl/slot_addr_decode.sv
module slot_addr_decode
   import slot_sel_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned GROUP_W   = 2,
   parameter int unsigned MASK_LSBS = 2
) (
   input  logic [ADDR_W-1:0]  ir_val,
   input  logic [ADDR_W-1:0]  slot_val,
   input  logic               mask_en,
   input  logic [GROUP_W-1:0] grp_val,
   output sel_kind_e          kind
);

   localparam int unsigned NGRP = 1 << GROUP_W;

   logic [NGRP-1:0] mc_hit;
   logic            hit_bcast;
   logic            hit_intg;
   logic            hit_mc_any;
   logic            hit_mc_mine;
   logic            slot_eq;
   logic            uniq_ok;

   assign hit_bcast = (ir_val == ADDR_W'(CODE_BCAST));
   assign hit_intg  = (ir_val == ADDR_W'(CODE_INTERROG));

   for (genvar g = 0; g < NGRP; g++) begin : g_mc
      assign mc_hit[g] = (ir_val == ADDR_W'(CODE_MCAST_BASE + g));
   end

   assign hit_mc_any  = |mc_hit;
   assign hit_mc_mine = mc_hit[grp_val];

   if (MASK_LSBS == 0) begin : g_nomask
      logic unused_mask;
      assign unused_mask = mask_en;
      assign slot_eq = (ir_val == slot_val);
   end else begin : g_mask
      localparam logic [ADDR_W-1:0] LOW_BITS = ADDR_W'((1 << MASK_LSBS) - 1);
      logic [ADDR_W-1:0] keep;
      assign keep    = mask_en ? ~LOW_BITS : {ADDR_W{1'b1}};
      assign slot_eq = (((ir_val ^ slot_val) & keep) == '0);
   end

   assign uniq_ok = !(hit_bcast || hit_intg || hit_mc_any)
                    && (slot_val != '0) && (ir_val != '0) && slot_eq;

   always_comb begin
      if (hit_intg)         kind = KIND_INTERROG;
      else if (hit_bcast)   kind = KIND_BCAST;
      else if (hit_mc_any)  kind = hit_mc_mine ? KIND_MCAST : KIND_NONE;
      else if (uniq_ok)     kind = KIND_UNIQUE;
      else                  kind = KIND_NONE;
   end

endmodule

// File: rtl/mcast_group_reg.sv
module mcast_group_reg #(
   parameter int unsigned GROUP_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               sel,
   input  logic [GROUP_W-1:0] din,
   output logic [GROUP_W-1:0] grp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         grp <= '0;
      else if (wr && sel) grp <= din;
   end

   // R9: a write while not selected leaves the group untouched
   p_grp_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && sel) |=> $stable(grp));

endmodule

// File: rtl/select_state.sv
module select_state
   import slot_sel_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tlr,
   input  logic      addr_upd,
   input  sel_kind_e kind,
   output logic      sel,
   output logic      oe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= 1'b0;
         oe  <= 1'b0;
      end else if (tlr) begin
         sel <= 1'b0;
         oe  <= 1'b0;
      end else if (addr_upd) begin
         unique case (kind)
            KIND_UNIQUE, KIND_INTERROG: begin
               sel <= 1'b1;
               oe  <= 1'b1;
            end
            KIND_BCAST, KIND_MCAST: begin
               sel <= 1'b1;
               oe  <= 1'b0;
            end
            default: begin
               sel <= 1'b0;
               oe  <= 1'b0;
            end
         endcase
      end
   end

   // R13: the driver may only be enabled on a selected device
   p_oe_needs_sel_r13: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> sel);

   // R12: flags hold between address loads
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_upd && !tlr) |=> ($stable(sel) && $stable(oe)));

   // R10: Test-Logic-Reset drops the selection
   p_tlr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tlr |=> (!sel && !oe));

endmodule

// File: rtl/jtag_slot_selector.sv
module jtag_slot_selector
   import slot_sel_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned GROUP_W   = 2,
   parameter int unsigned MASK_LSBS = 2
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tap_tlr,
   input  logic               upd_ir_addr,
   input  logic [ADDR_W-1:0]  ir_addr,
   input  logic [ADDR_W-1:0]  slot_id,
   input  logic               addr_mask,
   input  logic               grp_upd,
   input  logic [GROUP_W-1:0] grp_din,
   output logic               selected,
   output logic               bp_tdo_oe
);

   if (ADDR_W < CODE_MIN_W) begin : g_chk_w
      $error("ADDR_W too narrow for the reserved codes");
   end
   if (GROUP_W < 1 || GROUP_W > 2) begin : g_chk_g
      $error("GROUP_W must be 1 or 2 to keep group codes clear of other codes");
   end
   if (MASK_LSBS >= ADDR_W) begin : g_chk_m
      $error("MASK_LSBS must leave at least one compared bit");
   end

   sel_kind_e          kind;
   logic [GROUP_W-1:0] grp_q;

   slot_addr_decode #(
      .ADDR_W    (ADDR_W),
      .GROUP_W   (GROUP_W),
      .MASK_LSBS (MASK_LSBS)
   ) u_decode (
      .ir_val   (ir_addr),
      .slot_val (slot_id),
      .mask_en  (addr_mask),
      .grp_val  (grp_q),
      .kind     (kind)
   );

   mcast_group_reg #(
      .GROUP_W (GROUP_W)
   ) u_group (
      .clk   (tck),
      .rst_n (trst_n),
      .wr    (grp_upd),
      .sel   (selected),
      .din   (grp_din),
      .grp   (grp_q)
   );

   select_state u_state (
      .clk      (tck),
      .rst_n    (trst_n),
      .tlr      (tap_tlr),
      .addr_upd (upd_ir_addr),
      .kind     (kind),
      .sel      (selected),
      .oe       (bp_tdo_oe)
   );

   // R6: broadcast selects without driving the shared output
   p_bcast_r6: assert property (@(posedge tck) disable iff (!trst_n)
      (upd_ir_addr && !tap_tlr && ir_addr == ADDR_W'(CODE_BCAST))
      |=> (selected && !bp_tdo_oe));

   // R7: interrogation selects and drives
   p_intg_r7: assert property (@(posedge tck) disable iff (!trst_n)
      (upd_ir_addr && !tap_tlr && ir_addr == ADDR_W'(CODE_INTERROG))
      |=> (selected && bp_tdo_oe));

   // R4: an all-zero slot never matches a zero address
   p_zero_slot_r4: assert property (@(posedge tck) disable iff (!trst_n)
      (upd_ir_addr && !tap_tlr && slot_id == '0 && ir_addr == '0)
      |=> !selected);

endmodule

// File: tb/jtag_slot_selector_tb.sv
module jtag_slot_selector_tb;

   logic       tck = 1'b0;
   logic       trst_n = 1'b0;
   logic       tap_tlr = 1'b0;
   logic       upd_ir_addr = 1'b0;
   logic [7:0] ir_addr = '0;
   logic [7:0] slot_id = '0;
   logic       addr_mask = 1'b0;
   logic       grp_upd = 1'b0;
   logic [1:0] grp_din = '0;
   logic       selected;
   logic       bp_tdo_oe;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #2 tck = ~tck;

   jtag_slot_selector u_dut (
      .tck         (tck),
      .trst_n      (trst_n),
      .tap_tlr     (tap_tlr),
      .upd_ir_addr (upd_ir_addr),
      .ir_addr     (ir_addr),
      .slot_id     (slot_id),
      .addr_mask   (addr_mask),
      .grp_upd     (grp_upd),
      .grp_din     (grp_din),
      .selected    (selected),
      .bp_tdo_oe   (bp_tdo_oe)
   );

   task automatic chk(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
      end
   endtask

   task automatic chk_pair(input string tag, input logic es, input logic eo);
      chk({tag, " selected"}, selected, es);
      chk({tag, " oe"}, bp_tdo_oe, eo);
   endtask

   task automatic load_addr(input logic [7:0] v);
      @(negedge tck);
      ir_addr     = v;
      upd_ir_addr = 1'b1;
      @(negedge tck);
      upd_ir_addr = 1'b0;
   endtask

   task automatic write_group(input logic [1:0] g);
      @(negedge tck);
      grp_din = g;
      grp_upd = 1'b1;
      @(negedge tck);
      grp_upd = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge tck);
      trst_n = 1'b0;
      repeat (3) @(negedge tck);
      trst_n = 1'b1;
      @(negedge tck);
   endtask

   task automatic t_reset();
      do_reset();
      chk_pair("R1 after reset", 1'b0, 1'b0);
      load_addr(8'h3C);
      chk_pair("R1 group zero after reset", 1'b1, 1'b0);
   endtask

   task automatic t_unique();
      slot_id = 8'h15; addr_mask = 1'b0;
      load_addr(8'h15);
      chk_pair("R2 unique match", 1'b1, 1'b1);
   endtask

   task automatic t_hold();
      repeat (6) @(negedge tck);
      chk_pair("R12 hold", 1'b1, 1'b1);
   endtask

   task automatic t_mismatch();
      load_addr(8'h16);
      chk_pair("R3 mismatch", 1'b0, 1'b0);
   endtask

   task automatic t_zero();
      slot_id = 8'h00; addr_mask = 1'b0;
      load_addr(8'h00);
      chk_pair("R4 zero slot", 1'b0, 1'b0);
      addr_mask = 1'b1;
      load_addr(8'h01);
      chk_pair("R4 zero slot masked", 1'b0, 1'b0);
      addr_mask = 1'b0;
   endtask

   task automatic t_mask();
      slot_id = 8'h15; addr_mask = 1'b1;
      load_addr(8'h17);
      chk_pair("R5 masked low bits", 1'b1, 1'b1);
      load_addr(8'h19);
      chk_pair("R5 masked high bit differs", 1'b0, 1'b0);
      addr_mask = 1'b0;
      load_addr(8'h17);
      chk_pair("R5 unmasked low bits", 1'b0, 1'b0);
   endtask

   task automatic t_bcast();
      load_addr(8'h38);
      chk_pair("R6 broadcast", 1'b1, 1'b0);
   endtask

   task automatic t_interrog();
      load_addr(8'h3A);
      chk_pair("R7 interrogation", 1'b1, 1'b1);
   endtask

   task automatic t_mcast();
      slot_id = 8'h15; addr_mask = 1'b0;
      load_addr(8'h15);
      write_group(2'd2);
      load_addr(8'h3E);
      chk_pair("R8 multicast own group", 1'b1, 1'b0);
      load_addr(8'h3D);
      chk_pair("R8 multicast other group", 1'b0, 1'b0);
   endtask

   task automatic t_group_ignore();
      load_addr(8'h20);
      write_group(2'd1);
      load_addr(8'h3D);
      chk_pair("R9 ignored write group1", 1'b0, 1'b0);
      load_addr(8'h3E);
      chk_pair("R9 group kept at 2", 1'b1, 1'b0);
   endtask

   task automatic t_tlr();
      load_addr(8'h15);
      @(negedge tck);
      tap_tlr = 1'b1;
      ir_addr = 8'h15;
      upd_ir_addr = 1'b1;
      @(negedge tck);
      tap_tlr = 1'b0;
      upd_ir_addr = 1'b0;
      chk_pair("R10 tlr clears", 1'b0, 1'b0);
      load_addr(8'h3E);
      chk_pair("R10 group survives tlr", 1'b1, 1'b0);
      load_addr(8'h15);
      chk("R13 oe with selected", bp_tdo_oe, 1'b1);
   endtask

   task automatic t_reserved();
      slot_id = 8'h38;
      load_addr(8'h38);
      chk_pair("R11 reserved over slot", 1'b1, 1'b0);
      slot_id = 8'h3A;
      load_addr(8'h38);
      chk_pair("R11 slot 3A gets broadcast", 1'b1, 1'b0);
   endtask

   task automatic t_reset_group();
      slot_id = 8'h15;
      do_reset();
      load_addr(8'h3E);
      chk_pair("R1 reset clears group", 1'b0, 1'b0);
   endtask

   bit done = 1'b0;

   initial begin
      t_reset();
      t_unique();
      t_hold();
      t_mismatch();
      t_zero();
      t_mask();
      t_bcast();
      t_interrog();
      t_mcast();
      t_group_ignore();
      t_tlr();
      t_reserved();
      t_reset_group();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   always @(posedge tck) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog got=%0d exp=%0d", cycles, 20000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule